// File: doc/BRIEF.md
# Programmable-Order Fractional Delta-Sigma Sequencer

This block produces the per-reference-cycle offset that a fractional-N divider adds to its integer divide value. A configuration strobe captures a fractional numerator, a denominator, a modulator order, a dither strength and a fraction-width mode. From the next cycle on, the block emits one signed offset per clock. Over time the average of these offsets equals numerator/denominator, and the quantisation noise is pushed to high frequency by a cascade of up to four first-order accumulators.

Each accumulator wraps modulo the denominator. The carries of the active stages are merged through repeated first differences, so the offset spans -(2^(k-1)-1) to +2^(k-1) for order k. A pseudo-random dither bit can be added to the least significant bit of the first accumulator. It can be added on every step, on every eighth step, or not at all, and it is never added when the numerator is zero. An integer setting holds the offset at zero and ignores the fraction entirely.

The reset is asynchronous and active-low. The surrounding logic is expected to release it synchronously with the clock.

Top module: `dsm_frac_seq`

## Requirements
- R1: `cfg_order` selects the order: 0 gives fourth order, 2 gives second order, 3 gives third order. For order k, stage j (1..k) adds the previous stage's new residue, or the numerator plus the dither bit for stage 1, to its residue. It raises carry c_j when the sum reaches the denominator D and then subtracts D. The offset is the sum over j of the (j-1)-th backward difference of c_j, with carry history taken as zero before the load. The offset stays within -(2^(k-1)-1)..2^(k-1).
- R2: `cfg_order` = 1 is integer mode. The fraction inputs are ignored and every valid offset is zero.
- R3: After the width mode is applied, an effective denominator of zero, or an effective numerator not below the effective denominator, is treated as integer mode.
- R4: With `cfg_wide` = 1, all 22 bits of numerator and denominator are used. With `cfg_wide` = 0, bits [21:12] of both are taken as zero.
- R5: `cfg_dither` = 2 injects dither on every step. `cfg_dither` = 0 injects only on steps whose index since the load is a multiple of 8, counting from index 0. Codes 3 and 1 inject nothing.
- R6: The dither bit is bit 0 of a 16-bit shift register. The register is seeded to 0xACE1 at each load and advances once per non-integer step as {r[14:0], r[15]^r[13]^r[12]^r[10]}. The bit is added to the first stage on the steps that R5 allows.
- R7: When the effective numerator is zero, no dither is applied, so the offset stays zero.
- R8: The clock edge that samples `cfg_load` clears all residues, carry history, dither state and the step index, and drives `ofs_vld` low with offset zero. From the following edge on, `ofs_vld` is high and the first offset is step 0.
- R9: With dither off, the sum of the first D offsets after a load differs from the effective numerator by at most 2^(k-1).
- R10: From reset until the first load, `ofs_vld` and `ofs` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference-rate clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_load | input | 1 | Captures the configuration and restarts the modulator |
| cfg_order | input | 2 | Order select (0: fourth, 1: integer, 2: second, 3: third) |
| cfg_dither | input | 2 | Dither select (0: weak, 1: none, 2: strong, 3: none) |
| cfg_wide | input | 1 | 1: 22-bit fraction, 0: 12-bit fraction |
| cfg_num | input | 22 | Fractional numerator |
| cfg_den | input | 22 | Fractional denominator |
| ofs | output | 5 | Signed divide offset for this reference cycle |
| ofs_vld | output | 1 | Offset valid since the cycle after a load |

## Verification
The hardest case to reach is a fourth-order run in which the weak-dither cadence and the shift-register bit line up on the same step. This has to happen while the carry history is deep enough to swing the offset toward its extremes. The stimulus uses small denominators near the numerator so that all four carries toggle often. It runs weak and strong dither for several hundred steps each, and it reloads in the middle of a run so that the step index and the shift register restart at a known phase. A behavioural model compares every cycle, so a misplaced injection shows up within a few steps.

// File: rtl/dsm_pkg.sv
package dsm_pkg;

  typedef enum logic [1:0] {
    ORD_FOURTH = 2'd0,
    ORD_HOLD   = 2'd1,
    ORD_SECOND = 2'd2,
    ORD_THIRD  = 2'd3
  } ord_e;

  typedef enum logic [1:0] {
    DTH_WEAK   = 2'd0,
    DTH_RSVD   = 2'd1,
    DTH_STRONG = 2'd2,
    DTH_OFF    = 2'd3
  } dth_e;

  // number of cascade stages an order code switches on
  function automatic int unsigned order_stages(ord_e o);
    case (o)
      ORD_FOURTH: return 4;
      ORD_SECOND: return 2;
      ORD_THIRD:  return 3;
      default:    return 0;
    endcase
  endfunction

endpackage

// File: rtl/dsm_acc_stage.sv
module dsm_acc_stage #(
  parameter int W = 22
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         en,
  input  logic         active,
  input  logic [W-1:0] add_in,
  input  logic         dith_in,
  input  logic [W-1:0] den,
  output logic [W-1:0] acc_nxt,
  output logic         carry
);

  logic [W-1:0] acc_q, acc_d;
  logic [W:0]   sum;
  logic [W-1:0] wrap;

  // sum is at most 2*den-1, so one subtraction restores the residue
  always_comb begin
    sum     = {1'b0, acc_q} + {1'b0, add_in} + {{W{1'b0}}, dith_in};
    wrap    = sum[W-1:0] - den;
    carry   = active && (sum >= {1'b0, den});
    if (!active)   acc_nxt = acc_q;
    else if (carry) acc_nxt = wrap;
    else            acc_nxt = sum[W-1:0];
  end

  always_comb begin
    if (clr)     acc_d = '0;
    else if (en) acc_d = acc_nxt;
    else         acc_d = acc_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) acc_q <= '0;
    else        acc_q <= acc_d;
  end

  AST_RESIDUE_BELOW_DEN: assert property (@(posedge clk) disable iff (!rst_n)
    (en && active) |-> (acc_q < den)); // R1
  AST_RESIDUE_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (acc_q == '0)); // R8

endmodule

// File: rtl/dsm_noise_shaper.sv
module dsm_noise_shaper #(
  parameter int STAGES = 4,
  parameter int OUT_W  = STAGES + 1
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    clr,
  input  logic                    en,
  input  logic [STAGES-1:0]       carry,
  output logic signed [OUT_W-1:0] y_o
);

  localparam int PAD = OUT_W - 1;

  logic signed [OUT_W-1:0] y    [STAGES];
  logic signed [OUT_W-1:0] yd_q [1:STAGES-1];
  logic signed [OUT_W-1:0] yd_d [1:STAGES-1];

  // deepest stage passes its carry straight up
  assign y[STAGES-1] = $signed({{PAD{1'b0}}, carry[STAGES-1]});

  // each shallower stage adds the first difference of the one below
  for (genvar k = 0; k < STAGES - 1; k++) begin : g_merge
    assign y[k] = $signed({{PAD{1'b0}}, carry[k]}) + y[k+1] - yd_q[k+1];
  end

  for (genvar k = 1; k < STAGES; k++) begin : g_delay
    always_comb begin
      if (clr)     yd_d[k] = '0;
      else if (en) yd_d[k] = y[k];
      else         yd_d[k] = yd_q[k];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) yd_q[k] <= '0;
      else        yd_q[k] <= yd_d[k];
    end

    AST_HISTORY_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> (yd_q[k] == '0)); // R8
  end

  assign y_o = y[0];

endmodule

// File: rtl/dsm_dither_gen.sv
module dsm_dither_gen
  import dsm_pkg::*;
#(
  parameter logic [15:0] SEED  = 16'hACE1,
  parameter int          CNT_W = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic en,
  input  dth_e mode,
  input  logic allow,
  output logic bit_o
);

  logic [15:0]      lfsr_q, lfsr_d, lfsr_adv;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             inject;

  always_comb begin
    lfsr_adv = {lfsr_q[14:0], lfsr_q[15] ^ lfsr_q[13] ^ lfsr_q[12] ^ lfsr_q[10]};
    inject   = allow && ((mode == DTH_STRONG) ||
                         ((mode == DTH_WEAK) && (cnt_q == '0)));
    bit_o    = inject && lfsr_q[0];
  end

  always_comb begin
    if (clr) begin
      lfsr_d = SEED;
      cnt_d  = '0;
    end else if (en) begin
      lfsr_d = lfsr_adv;
      cnt_d  = cnt_q + CNT_W'(1);
    end else begin
      lfsr_d = lfsr_q;
      cnt_d  = cnt_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lfsr_q <= SEED;
      cnt_q  <= '0;
    end else begin
      lfsr_q <= lfsr_d;
      cnt_q  <= cnt_d;
    end
  end

  AST_WEAK_CADENCE: assert property (@(posedge clk) disable iff (!rst_n)
    ((mode == DTH_WEAK) && bit_o) |-> (cnt_q == '0)); // R5
  AST_QUIET_CODES: assert property (@(posedge clk) disable iff (!rst_n)
    ((mode == DTH_OFF) || (mode == DTH_RSVD)) |-> !bit_o); // R5
  AST_SEED_AFTER_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (lfsr_q == SEED)); // R6

endmodule

// File: rtl/dsm_frac_seq.sv
module dsm_frac_seq
  import dsm_pkg::*;
#(
  parameter int          FRAC_W   = 22,
  parameter int          NARROW_W = 12,
  parameter int          STAGES   = 4,
  parameter logic [15:0] LFSR_SEED = 16'hACE1,
  parameter int          WEAK_LG  = 3
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           cfg_load,
  input  logic [1:0]                     cfg_order,
  input  logic [1:0]                     cfg_dither,
  input  logic                           cfg_wide,
  input  logic [FRAC_W-1:0]              cfg_num,
  input  logic [FRAC_W-1:0]              cfg_den,
  output logic signed [STAGES:0]         ofs,
  output logic                           ofs_vld
);

  localparam int OFS_W = STAGES + 1;
  localparam int EXT_W = FRAC_W - NARROW_W;
  localparam int NW    = $clog2(STAGES + 1);

  // captured configuration
  logic              loaded_q, loaded_d;
  logic              hold_q, hold_d;
  dth_e              dth_q, dth_d;
  logic [FRAC_W-1:0] num_q, num_d;
  logic [FRAC_W-1:0] den_q, den_d;
  logic [STAGES-1:0] act_q, act_d;
  logic [NW-1:0]     n_q, n_d;

  logic [FRAC_W-1:0] num_eff, den_eff;
  int unsigned       n_sel;

  logic              step_en;
  logic              dith_bit;
  logic [STAGES-1:0] carry;
  logic [FRAC_W-1:0] nxt [STAGES];
  logic signed [OFS_W-1:0] shaped;

  logic signed [OFS_W-1:0] ofs_d;
  logic                    vld_d;

  // ---------------- configuration capture ----------------
  always_comb begin
    num_eff = cfg_wide ? cfg_num : {{EXT_W{1'b0}}, cfg_num[NARROW_W-1:0]};
    den_eff = cfg_wide ? cfg_den : {{EXT_W{1'b0}}, cfg_den[NARROW_W-1:0]};
    n_sel   = order_stages(ord_e'(cfg_order));
  end

  always_comb begin
    loaded_d = loaded_q;
    hold_d   = hold_q;
    dth_d    = dth_q;
    num_d    = num_q;
    den_d    = den_q;
    act_d    = act_q;
    n_d      = n_q;
    if (cfg_load) begin
      loaded_d = 1'b1;
      hold_d   = (ord_e'(cfg_order) == ORD_HOLD) || (den_eff == '0) ||
                 (num_eff >= den_eff);
      dth_d    = dth_e'(cfg_dither);
      num_d    = num_eff;
      den_d    = den_eff;
      n_d      = NW'(n_sel);
      for (int j = 0; j < STAGES; j++) begin
        act_d[j] = (j < int'(n_sel));
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      loaded_q <= 1'b0;
      hold_q   <= 1'b1;
      dth_q    <= DTH_OFF;
      num_q    <= '0;
      den_q    <= '0;
      act_q    <= '0;
      n_q      <= '0;
    end else begin
      loaded_q <= loaded_d;
      hold_q   <= hold_d;
      dth_q    <= dth_d;
      num_q    <= num_d;
      den_q    <= den_d;
      act_q    <= act_d;
      n_q      <= n_d;
    end
  end

  assign step_en = loaded_q && !cfg_load && !hold_q;

  // ---------------- dither source ----------------
  dsm_dither_gen #(
    .SEED  (LFSR_SEED),
    .CNT_W (WEAK_LG)
  ) u_dither (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (cfg_load),
    .en    (step_en),
    .mode  (dth_q),
    .allow (num_q != '0),
    .bit_o (dith_bit)
  );

  // ---------------- accumulator cascade ----------------
  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    logic [FRAC_W-1:0] feed;
    logic              dbit;
    if (g == 0) begin : g_head
      assign feed = num_q;
      assign dbit = dith_bit;
    end else begin : g_body
      assign feed = nxt[g-1];
      assign dbit = 1'b0;
    end

    dsm_acc_stage #(
      .W (FRAC_W)
    ) u_acc (
      .clk     (clk),
      .rst_n   (rst_n),
      .clr     (cfg_load),
      .en      (step_en),
      .active  (act_q[g]),
      .add_in  (feed),
      .dith_in (dbit),
      .den     (den_q),
      .acc_nxt (nxt[g]),
      .carry   (carry[g])
    );
  end

  // ---------------- carry merge ----------------
  dsm_noise_shaper #(
    .STAGES (STAGES),
    .OUT_W  (OFS_W)
  ) u_shape (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (cfg_load),
    .en    (step_en),
    .carry (carry),
    .y_o   (shaped)
  );

  // ---------------- output register ----------------
  always_comb begin
    ofs_d = ofs;
    vld_d = ofs_vld;
    if (cfg_load) begin
      ofs_d = '0;
      vld_d = 1'b0;
    end else if (loaded_q) begin
      vld_d = 1'b1;
      ofs_d = hold_q ? '0 : shaped;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ofs     <= '0;
      ofs_vld <= 1'b0;
    end else begin
      ofs     <= ofs_d;
      ofs_vld <= vld_d;
    end
  end

  // ---------------- checks ----------------
  int span_hi, span_lo;
  always_comb begin
    span_hi = (n_q == '0) ? 0 : (1 << (int'(n_q) - 1));
    span_lo = (n_q == '0) ? 0 : -(span_hi - 1);
  end

  AST_HOLD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (ofs_vld && hold_q) |-> (ofs == '0)); // R2
  AST_OFFSET_SPAN: assert property (@(posedge clk) disable iff (!rst_n)
    (ofs_vld && !hold_q) |-> ((int'(ofs) <= span_hi) && (int'(ofs) >= span_lo))); // R1
  AST_TAIL_RESIDUE: assert property (@(posedge clk) disable iff (!rst_n)
    step_en |-> (nxt[STAGES-1] < den_q)); // R1
  AST_LOAD_DROPS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_load |=> (!ofs_vld && (ofs == '0))); // R8
  AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_load && $past(cfg_load)) |=> ofs_vld); // R8
  AST_NO_DITH_ZERO_NUM: assert property (@(posedge clk) disable iff (!rst_n)
    (num_q == '0) |-> !dith_bit); // R7
  AST_IDLE_BEFORE_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    !loaded_q |-> (!ofs_vld && (ofs == '0))); // R10

endmodule

// File: tb/dsm_frac_seq_tb.sv
module dsm_frac_seq_tb;

  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 150000;

  logic              clk = 1'b0;
  logic              rst_n;
  logic              cfg_load;
  logic [1:0]        cfg_order;
  logic [1:0]        cfg_dither;
  logic              cfg_wide;
  logic [21:0]       cfg_num;
  logic [21:0]       cfg_den;
  logic signed [4:0] ofs;
  logic              ofs_vld;

  always #(CLK_PERIOD / 2) clk = ~clk;

  dsm_frac_seq u_dut (
    .clk        (clk),
    .rst_n      (rst_n),
    .cfg_load   (cfg_load),
    .cfg_order  (cfg_order),
    .cfg_dither (cfg_dither),
    .cfg_wide   (cfg_wide),
    .cfg_num    (cfg_num),
    .cfg_den    (cfg_den),
    .ofs        (ofs),
    .ofs_vld    (ofs_vld)
  );

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  // behavioural reference state
  int m_loaded, m_hold, m_n, m_dth, m_num, m_den;
  int m_vld, m_ofs, m_lfsr, m_step;
  int acc [4];
  int hist [4][3];
  int run_sum;

  task automatic chk(string req, string what, int got, int exp);
    total++;
    if (got != exp) begin
      bad++;
      $display("FAIL %s %s: got %0d expected %0d", req, what, got, exp);
    end
  endtask

  function automatic int binom(int n, int k);
    int r = 1;
    for (int i = 0; i < k; i++) r = r * (n - i) / (i + 1);
    return r;
  endfunction

  function automatic int stages_for(int code);
    case (code)
      0: return 4;
      2: return 2;
      3: return 3;
      default: return 0;
    endcase
  endfunction

  task automatic clear_model();
    for (int j = 0; j < 4; j++) begin
      acc[j] = 0;
      for (int i = 0; i < 3; i++) hist[j][i] = 0;
    end
    m_lfsr = 16'hACE1;
    m_step = 0;
  endtask

  // mirrors one clock edge from the requirement text
  task automatic m_edge();
    int c [4];
    int d, s, feed, y, fb;
    if (!rst_n) begin
      m_loaded = 0; m_vld = 0; m_ofs = 0; m_hold = 1;
      clear_model();
    end else if (cfg_load) begin
      m_num = cfg_wide ? int'(cfg_num) : int'(cfg_num & 22'hFFF);
      m_den = cfg_wide ? int'(cfg_den) : int'(cfg_den & 22'hFFF);
      m_n   = stages_for(int'(cfg_order));
      m_dth = int'(cfg_dither);
      m_hold = (cfg_order == 2'd1) || (m_den == 0) || (m_num >= m_den);
      m_loaded = 1; m_vld = 0; m_ofs = 0;
      clear_model();
    end else if (m_loaded != 0) begin
      m_vld = 1;
      if (m_hold != 0) begin
        m_ofs = 0;
      end else begin
        d = 0;
        if (m_num != 0 && (m_dth == 2 || (m_dth == 0 && (m_step % 8) == 0)))
          d = m_lfsr & 1;
        feed = m_num;
        for (int j = 0; j < 4; j++) begin
          c[j] = 0;
          if (j < m_n) begin
            s = acc[j] + feed + ((j == 0) ? d : 0);
            if (s >= m_den) begin c[j] = 1; s = s - m_den; end
            acc[j] = s;
            feed = s;
          end
        end
        y = 0;
        for (int j = 0; j < 4; j++) begin
          y += c[j];
          for (int i = 1; i <= j; i++)
            y += ((i % 2) ? -1 : 1) * binom(j, i) * hist[j][i-1];
        end
        for (int j = 0; j < 4; j++) begin
          hist[j][2] = hist[j][1];
          hist[j][1] = hist[j][0];
          hist[j][0] = c[j];
        end
        fb = ((m_lfsr >> 15) ^ (m_lfsr >> 13) ^ (m_lfsr >> 12) ^ (m_lfsr >> 10)) & 1;
        m_lfsr = ((m_lfsr << 1) | fb) & 16'hFFFF;
        m_step++;
        m_ofs = y;
      end
    end
  endtask

  task automatic step(string req, bit must_zero);
    int got;
    @(posedge clk);
    m_edge();
    @(negedge clk);
    got = ofs;
    chk(req, "valid", int'(ofs_vld), m_vld);
    chk(req, "offset", got, m_ofs);
    if (must_zero) chk(req, "offset held at zero", got, 0);
    if (ofs_vld) run_sum += got;
  endtask

  task automatic run(string req, int n, bit must_zero);
    for (int i = 0; i < n; i++) step(req, must_zero);
  endtask

  task automatic load(int ord, int dth, bit wide, int num, int den);
    cfg_order  = 2'(ord);
    cfg_dither = 2'(dth);
    cfg_wide   = wide;
    cfg_num    = 22'(num);
    cfg_den    = 22'(den);
    cfg_load   = 1'b1;
    step("R8", 1'b0);
    chk("R8", "valid low after load edge", int'(ofs_vld), 0);
    cfg_load   = 1'b0;
    step("R8", 1'b0);
    chk("R8", "valid high one cycle later", int'(ofs_vld), 1);
    run_sum = int'(ofs);
  endtask

  // R9: first D offsets after load sum to the numerator within 2^(k-1)
  task automatic mean_check(int num, int den, int k);
    int diff;
    run("R9", den - 1, 1'b0);
    diff = run_sum - num;
    if (diff < 0) diff = -diff;
    total++;
    if (diff > (1 << (k - 1))) begin
      bad++;
      $display("FAIL R9 mean: got sum %0d expected %0d (+/-%0d)", run_sum, num, 1 << (k - 1));
    end
  endtask

  initial begin
    rst_n = 1'b0; cfg_load = 1'b0; cfg_order = 2'd1; cfg_dither = 2'd3;
    cfg_wide = 1'b0; cfg_num = '0; cfg_den = '0; run_sum = 0;
    m_loaded = 0; m_vld = 0; m_ofs = 0; m_hold = 1;
    m_n = 0; m_dth = 3; m_num = 0; m_den = 0;
    clear_model();
    repeat (3) @(negedge clk);
    chk("R10", "valid in reset", int'(ofs_vld), 0);
    chk("R10", "offset in reset", int'(ofs), 0);
    rst_n = 1'b1;
    run("R10", 5, 1'b1);

    // R1 second order, narrow, no dither, plus R9
    load(2, 3, 1'b0, 5, 17);
    mean_check(5, 17, 2);
    run("R1", 40, 1'b0);

    // R1 fourth order near-full fraction, plus R9
    load(0, 3, 1'b0, 33, 37);
    mean_check(33, 37, 4);
    run("R1", 150, 1'b0);

    // R1 third order
    load(3, 3, 1'b0, 200, 1001);
    run("R1", 300, 1'b0);

    // R5 reserved dither code acts as no dither, wide fraction
    load(3, 1, 1'b1, 22'h02ABCD, 22'h300001);
    run("R5", 200, 1'b0);

    // R2 integer code ignores fraction
    load(1, 2, 1'b1, 700, 1000);
    run("R2", 50, 1'b1);

    // R3 zero denominator
    load(2, 3, 1'b1, 5, 0);
    run("R3", 20, 1'b1);

    // R3 wide numerator above denominator
    load(0, 3, 1'b1, 22'h3FF123, 22'h100FFF);
    run("R3", 20, 1'b1);

    // R4 same words in narrow mode use the low 12 bits only
    load(0, 3, 1'b0, 22'h3FF123, 22'h100FFF);
    run("R4", 200, 1'b0);

    // R6 strong dither on every step
    load(3, 2, 1'b0, 77, 1000);
    run("R6", 300, 1'b0);

    // R5 weak dither every eighth step, fourth order
    load(0, 0, 1'b0, 77, 100);
    run("R5", 300, 1'b0);

    // R7 zero numerator with strong dither stays silent
    load(2, 2, 1'b0, 0, 1000);
    run("R7", 60, 1'b1);

    // R8 reload mid-run restarts phase
    load(0, 2, 1'b1, 12345, 99991);
    run("R8", 13, 1'b0);
    load(0, 2, 1'b1, 12345, 99991);
    run("R8", 40, 1'b0);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      bad++;
      total++;
      $display("FAIL R8 watchdog: got no finish expected finish within %0d cycles", WATCHDOG);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule